// File: doc/BRIEF.md
# GPIO Port with Interrupt Cause Logic

A general-purpose I/O port of `NUM_PINS` pins (32 by default) behind a small register bus. Software programs output levels, pin directions, a per-pin blink selection and a per-pin input inversion. It reads back the polarity-adjusted input levels. Writes take effect at the clock edge on which `bus_wr` is sampled high. Reads are combinational from `bus_addr`.

Every pin can raise an interrupt in two ways. The first is a level cause: the adjusted input ANDed with a level mask. The second is a latched edge cause, set when the adjusted input goes from 0 to 1 and gated by an edge mask. Software chooses falling-edge detection by inverting the pin with its polarity bit. Software acknowledges an edge cause by writing 0 to its bit. The masked causes are ORed into one interrupt line for each group of `GROUP` pins.

Output pins can blink. A free-running counter produces a square wave, and any output pin with its blink bit set follows that wave instead of its output register bit.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, output, blink, polarity, edge cause, edge mask and level mask are all zero, and every direction bit is 1 (all pins are inputs). As a result `pin_oe` and `irq_group` are zero.
- R2: Each writable register reads back the value last written at its address.
  - Output is at 0x00, direction at 0x04, blink at 0x08 and polarity at 0x0C.
  - Edge mask is at 0x18+MASK_OFS and level mask is at 0x1C+MASK_OFS.
  - Any unmapped address, including 0x18 and 0x1C when MASK_OFS is not 0, reads zero.
  - A write to the data-in address 0x10 has no effect.
- R3: A direction bit of 1 makes the pin an input (`pin_oe` bit 0). A direction bit of 0 drives the pin (`pin_oe` bit 1). A driven pin without blink shows its output register bit on `pin_out` from the cycle after the write.
- R4: Data-in (0x10) bit n equals `pin_in[n]` XOR polarity bit n. A pin change becomes visible there after exactly two rising clock edges, and not after one.
- R5: A pin whose data-in bit is 1 and whose level-mask bit is 1 raises its group's interrupt line. A pin with a clear level-mask bit does not.
- R6: An edge cause bit (read at 0x14) is set by a 0-to-1 change of its data-in bit and is readable after three rising edges from the pin change. A 1-to-0 change sets nothing. With a polarity bit of 1, a falling pin sets the cause.
- R7: Writing 0 to an edge cause bit clears it, and writing 1 leaves it unchanged. If a new edge arrives in the same cycle as a clearing write, the bit ends up set.
- R8: `irq_group[g]` is the OR over pins g*GROUP to g*GROUP+GROUP-1 of the level-masked data-in and the edge cause ANDed with the edge mask. An edge cause whose mask bit is 0 does not raise an interrupt.
- R9: A driven pin with its blink bit set toggles every BLINK_TERM+1 cycles. All blinking pins share one phase, and pins without blink keep their output register bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Pin drive values |
| pin_oe | output | NUM_PINS | Pin drive enables, 1 = drive |
| irq_group | output | NUM_PINS/GROUP | One interrupt line per group of pins |

## Verification
Register writes show at the ports and on reads in the first cycle after the write edge. A pin change reaches data-in and the level interrupt after two edges, and reaches the edge cause after three. The bench drives pins and bus on falling edges and samples after exactly that many rising edges. At the two-edge point it also confirms the edge cause is still clear, and at the one-edge point it confirms the old data-in value. The clear-versus-set race is produced by timing the clearing write onto the third edge after the pin change. Blink timing is measured by counting toggles over a window of whole periods.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   // Register byte offsets; the two masks additionally move by MASK_OFS.
   localparam int unsigned OFS_OUT    = 'h00;
   localparam int unsigned OFS_DIR    = 'h04;
   localparam int unsigned OFS_BLINK  = 'h08;
   localparam int unsigned OFS_POL    = 'h0C;
   localparam int unsigned OFS_DIN    = 'h10;
   localparam int unsigned OFS_ECAUSE = 'h14;
   localparam int unsigned OFS_EMASK  = 'h18;
   localparam int unsigned OFS_LMASK  = 'h1C;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage1_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1_q <= '0;
         q        <= '0;
      end else begin
         stage1_q <= d;
         q        <= stage1_q;
      end
   end
endmodule

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen #(
   parameter int TERM = 1023
) (
   input  logic clk,
   input  logic rst_n,
   output logic phase
);
   localparam int CNT_W = (TERM < 1) ? 1 : $clog2(TERM + 1);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (TERM < 1) begin : g_bad_term
         $error("gpio_blink_gen: TERM must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         phase <= 1'b0;
      end else if (cnt_q == CNT_W'(TERM)) begin
         cnt_q <= '0;
         phase <= ~phase;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/gpio_irq_cause.sv
module gpio_irq_cause #(
   parameter int NUM_PINS = 32,
   parameter int GROUP    = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_PINS-1:0]        data_in,
   input  logic                       cause_wr,
   input  logic [NUM_PINS-1:0]        cause_wdata,
   input  logic [NUM_PINS-1:0]        emask,
   input  logic [NUM_PINS-1:0]        lmask,
   output logic [NUM_PINS-1:0]        cause_q,
   output logic [NUM_PINS-1:0]        edge_rise,
   output logic [NUM_PINS/GROUP-1:0]  irq_group
);
   localparam int NG = NUM_PINS / GROUP;

   logic [NUM_PINS-1:0] prev_q;
   logic [NUM_PINS-1:0] hit;

   assign edge_rise = data_in & ~prev_q;

   // A new edge is ORed in after the clearing AND, so it is never lost.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         cause_q <= '0;
      end else begin
         prev_q <= data_in;
         if (cause_wr) cause_q <= (cause_q & cause_wdata) | edge_rise;
         else          cause_q <= cause_q | edge_rise;
      end
   end

   assign hit = (data_in & lmask) | (cause_q & emask);

   generate
      for (genvar g = 0; g < NG; g++) begin : g_grp
         assign irq_group[g] = |hit[g*GROUP +: GROUP];
      end
   endgenerate
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PINS   = 32,
   parameter int GROUP      = 8,
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int MASK_OFS   = 0,
   parameter int BLINK_TERM = 1023
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_wr,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [DATA_W-1:0]         bus_wdata,
   output logic [DATA_W-1:0]         bus_rdata,
   input  logic [NUM_PINS-1:0]       pin_in,
   output logic [NUM_PINS-1:0]       pin_out,
   output logic [NUM_PINS-1:0]       pin_oe,
   output logic [NUM_PINS/GROUP-1:0] irq_group
);
   localparam int NG = NUM_PINS / GROUP;
   localparam logic [ADDR_W-1:0] A_OUT    = ADDR_W'(OFS_OUT);
   localparam logic [ADDR_W-1:0] A_DIR    = ADDR_W'(OFS_DIR);
   localparam logic [ADDR_W-1:0] A_BLINK  = ADDR_W'(OFS_BLINK);
   localparam logic [ADDR_W-1:0] A_POL    = ADDR_W'(OFS_POL);
   localparam logic [ADDR_W-1:0] A_DIN    = ADDR_W'(OFS_DIN);
   localparam logic [ADDR_W-1:0] A_ECAUSE = ADDR_W'(OFS_ECAUSE);
   localparam logic [ADDR_W-1:0] A_EMASK  = ADDR_W'(OFS_EMASK + MASK_OFS);
   localparam logic [ADDR_W-1:0] A_LMASK  = ADDR_W'(OFS_LMASK + MASK_OFS);

   generate
      if (NUM_PINS % GROUP != 0) begin : g_bad_group
         $error("gpio_irq_port: NUM_PINS must be a multiple of GROUP");
      end
      if (NUM_PINS > DATA_W) begin : g_bad_width
         $error("gpio_irq_port: NUM_PINS exceeds DATA_W");
      end
      if (NG < 1) begin : g_bad_ng
         $error("gpio_irq_port: at least one group is required");
      end
   endgenerate

   logic [NUM_PINS-1:0] out_q, dir_q, blink_q, pol_q, emask_q, lmask_q;
   logic [NUM_PINS-1:0] pin_sync, data_in, ecause, edge_rise, wpins, rsel;
   logic                blink_phase;

   assign wpins = bus_wdata[NUM_PINS-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q   <= '0;
         dir_q   <= '1;
         blink_q <= '0;
         pol_q   <= '0;
         emask_q <= '0;
         lmask_q <= '0;
      end else if (bus_wr) begin
         if (bus_addr == A_OUT)   out_q   <= wpins;
         if (bus_addr == A_DIR)   dir_q   <= wpins;
         if (bus_addr == A_BLINK) blink_q <= wpins;
         if (bus_addr == A_POL)   pol_q   <= wpins;
         if (bus_addr == A_EMASK) emask_q <= wpins;
         if (bus_addr == A_LMASK) lmask_q <= wpins;
      end
   end

   gpio_sync #(.W(NUM_PINS)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   assign data_in = pin_sync ^ pol_q;

   gpio_irq_cause #(.NUM_PINS(NUM_PINS), .GROUP(GROUP)) u_cause (
      .clk         (clk),
      .rst_n       (rst_n),
      .data_in     (data_in),
      .cause_wr    (bus_wr && (bus_addr == A_ECAUSE)),
      .cause_wdata (wpins),
      .emask       (emask_q),
      .lmask       (lmask_q),
      .cause_q     (ecause),
      .edge_rise   (edge_rise),
      .irq_group   (irq_group)
   );

   gpio_blink_gen #(.TERM(BLINK_TERM)) u_blink (
      .clk   (clk),
      .rst_n (rst_n),
      .phase (blink_phase)
   );

   assign pin_oe  = ~dir_q;
   assign pin_out = (blink_q & {NUM_PINS{blink_phase}}) | (~blink_q & out_q);

   always_comb begin
      case (bus_addr)
         A_OUT:    rsel = out_q;
         A_DIR:    rsel = dir_q;
         A_BLINK:  rsel = blink_q;
         A_POL:    rsel = pol_q;
         A_DIN:    rsel = data_in;
         A_ECAUSE: rsel = ecause;
         A_EMASK:  rsel = emask_q;
         A_LMASK:  rsel = lmask_q;
         default:  rsel = '0;
      endcase
      bus_rdata = DATA_W'(rsel);
   end
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PINS = 32,
   parameter int GROUP    = 8,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      bus_wr,
   input logic [ADDR_W-1:0]         bus_addr,
   input logic [DATA_W-1:0]         bus_wdata,
   input logic [NUM_PINS-1:0]       pin_out,
   input logic [NUM_PINS-1:0]       pin_oe,
   input logic [NUM_PINS/GROUP-1:0] irq_group,
   input logic [NUM_PINS-1:0]       blink_q,
   input logic [NUM_PINS-1:0]       ecause,
   input logic [NUM_PINS-1:0]       edge_rise,
   input logic [NUM_PINS-1:0]       emask_q,
   input logic [NUM_PINS-1:0]       lmask_q
);
   localparam logic [ADDR_W-1:0] A_OUT    = ADDR_W'(OFS_OUT);
   localparam logic [ADDR_W-1:0] A_DIR    = ADDR_W'(OFS_DIR);
   localparam logic [ADDR_W-1:0] A_ECAUSE = ADDR_W'(OFS_ECAUSE);

   assert_dir_drives_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_DIR) |=> (pin_oe == ~$past(bus_wdata[NUM_PINS-1:0])));

   assert_out_reaches_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_OUT) |=>
         (((pin_out ^ $past(bus_wdata[NUM_PINS-1:0])) & ~blink_q) == '0));

   assert_cause_needs_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((ecause & ~$past(ecause) & ~$past(edge_rise)) == '0));

   assert_zero_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_ECAUSE) |=>
         ((ecause & ~$past(bus_wdata[NUM_PINS-1:0]) & ~$past(edge_rise)) == '0));

   assert_edge_never_lost_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(edge_rise) & ~ecause) == '0));

   assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (emask_q == '0 && lmask_q == '0) |-> (irq_group == '0));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(
   .NUM_PINS (NUM_PINS),
   .GROUP    (GROUP),
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .irq_group (irq_group),
   .blink_q   (blink_q),
   .ecause    (ecause),
   .edge_rise (edge_rise),
   .emask_q   (emask_q),
   .lmask_q   (lmask_q)
);

// File: tb/gpio_irq_port_tb.sv
`timescale 1ns/1ps
module gpio_irq_port_tb;
   localparam int NP = 32;
   localparam int GP = 8;
   localparam int NG = NP / GP;
   localparam int MOFS = 'h20;
   localparam int TERM = 3;
   localparam logic [7:0] A_OUT = 8'h00, A_DIR = 8'h04, A_BLINK = 8'h08, A_POL = 8'h0C;
   localparam logic [7:0] A_DIN = 8'h10, A_EC = 8'h14;
   localparam logic [7:0] A_EM = 8'h18 + MOFS, A_LM = 8'h1C + MOFS;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe;
   logic [NG-1:0] irq_group;

   int total = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   gpio_irq_port #(.NUM_PINS(NP), .GROUP(GP), .ADDR_W(8), .DATA_W(32),
                   .MASK_OFS(MOFS), .BLINK_TERM(TERM)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq_group(irq_group));

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Called at a falling edge; the write lands on the next rising edge.
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic expect_reg(input logic [7:0] a, input logic [31:0] e, input string req);
      logic [31:0] v;
      rd(a, v);
      check(v == e, req, v, e);
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(150000 * 20);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, pat, expd;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);

      // R1 reset state
      check(pin_oe == '0, "R1 oe", pin_oe, 0);
      check(irq_group == '0, "R1 irq", 32'(irq_group), 0);
      expect_reg(A_DIR, 32'hFFFF_FFFF, "R1 dir");
      expect_reg(A_OUT, 0, "R1 out");
      expect_reg(A_BLINK, 0, "R1 blink");
      expect_reg(A_POL, 0, "R1 pol");
      expect_reg(A_EC, 0, "R1 ecause");
      expect_reg(A_EM, 0, "R1 emask");
      expect_reg(A_LM, 0, "R1 lmask");

      // R2 write/readback over all writable registers, two patterns
      for (int p = 0; p < 2; p++) begin
         pat = (p == 0) ? 32'hA5C3_0F96 : 32'h5A3C_F069;
         for (int k = 0; k < 6; k++) begin
            logic [7:0] a;
            case (k)
               0: a = A_OUT; 1: a = A_DIR; 2: a = A_BLINK;
               3: a = A_POL; 4: a = A_EM;  default: a = A_LM;
            endcase
            wr(a, pat ^ 32'(k));
            expect_reg(a, pat ^ 32'(k), "R2 readback");
         end
      end
      expect_reg(8'h18, 0, "R2 base mask offset unmapped");
      expect_reg(8'h1C, 0, "R2 base mask offset unmapped");
      expect_reg(8'h40, 0, "R2 unmapped");
      wr(A_POL, 0); wr(A_BLINK, 0); wr(A_EM, 0); wr(A_LM, 0); wr(A_OUT, 0);
      wr(A_DIN, 32'hFFFF_FFFF);
      expect_reg(A_DIN, 0, "R2 data-in write ignored");

      // R3 direction and output drive
      wr(A_DIR, 32'hFFFF_0000);
      check(pin_oe == 32'h0000_FFFF, "R3 oe", pin_oe, 32'h0000_FFFF);
      wr(A_OUT, 32'h1234_ABCD);
      check(pin_out == 32'h1234_ABCD, "R3 pin_out", pin_out, 32'h1234_ABCD);
      wr(A_DIR, 32'hFFFF_FFFF);
      check(pin_oe == '0, "R3 oe all inputs", pin_oe, 0);

      // R4 data-in = pin ^ polarity, two-edge latency
      for (int p = 0; p < 6; p++) begin
         logic [31:0] pol, pv;
         pol = 32'h0F0F_3355 * (p + 1);
         pv  = 32'h9E37_79B9 ^ (32'h1111_1111 << p);
         wr(A_POL, pol);
         pin_in = pv;
         cyc(1);
         if (p == 0) expect_reg(A_DIN, pol, "R4 not yet after one edge");
         cyc(1);
         expect_reg(A_DIN, pv ^ pol, "R4 data-in");
      end

      // R5/R8 level interrupt sweep, one pin at a time
      wr(A_POL, 0); pin_in = 0; wr(A_EM, 0); wr(A_LM, 32'hFFFF_FFFF);
      cyc(3);
      for (int i = 0; i < NP; i++) begin
         pin_in = 32'd1 << i;
         cyc(2);
         expd = 32'd1 << (i / GP);
         check(32'(irq_group) == expd, "R5 R8 level group", 32'(irq_group), expd);
         pin_in = 0;
         cyc(2);
         check(irq_group == '0, "R5 level release", 32'(irq_group), 0);
      end
      wr(A_LM, ~(32'd1 << 3));
      pin_in = 32'd1 << 3;
      cyc(3);
      check(irq_group == '0, "R5 level masked", 32'(irq_group), 0);
      pin_in = 0;
      wr(A_LM, 0);

      // R6 rising-edge cause sweep
      cyc(4);
      wr(A_EC, 0);
      expect_reg(A_EC, 0, "R6 cleared start");
      for (int i = 0; i < NP; i++) begin
         pin_in = 32'd1 << i;
         cyc(2);
         expect_reg(A_EC, 0, "R6 not yet after two edges");
         cyc(1);
         expect_reg(A_EC, 32'd1 << i, "R6 rise latched");
         pin_in = 0;
         cyc(3);
         expect_reg(A_EC, 32'd1 << i, "R6 fall sets nothing");
         wr(A_EC, ~(32'd1 << i));
         expect_reg(A_EC, 0, "R7 zero clears bit");
      end

      // R6 falling detection through polarity, R8 edge masking
      pin_in = '1;
      cyc(4);
      wr(A_POL, 32'hFFFF_FFFF);
      cyc(3);
      wr(A_EC, 0);
      expect_reg(A_EC, 0, "R6 cleared before fall");
      pin_in[7] = 1'b0;
      cyc(3);
      expect_reg(A_EC, 32'd1 << 7, "R6 falling with polarity");
      check(irq_group == '0, "R8 edge unmasked off", 32'(irq_group), 0);
      wr(A_EM, 32'd1 << 7);
      check(32'(irq_group) == 32'd1, "R8 edge masked in", 32'(irq_group), 1);
      wr(A_EM, 32'd1 << 8);
      check(irq_group == '0, "R8 other mask bit", 32'(irq_group), 0);
      wr(A_EM, 0);

      // R7 write-one keeps, write-zero clears
      wr(A_EC, 32'hFFFF_FFFF);
      expect_reg(A_EC, 32'd1 << 7, "R7 write one keeps");
      wr(A_EC, 0);
      expect_reg(A_EC, 0, "R7 write zero clears");
      pin_in[7] = 1'b1;
      cyc(4);
      expect_reg(A_EC, 0, "R7 quiet after restore");

      // R7 new edge in the same cycle as a clearing write
      pin_in[20] = 1'b0;
      cyc(2);
      wr(A_EC, 0);
      expect_reg(A_EC, 32'd1 << 20, "R7 set wins over clear");
      wr(A_EC, 0);
      expect_reg(A_EC, 0, "R7 clear afterwards");

      // R9 blink
      wr(A_POL, 0);
      wr(A_OUT, 32'd1 << 5);
      wr(A_DIR, 32'h0000_0000);
      wr(A_BLINK, (32'd1 << 4) | (32'd1 << 30));
      begin
         int toggles = 0;
         int mism = 0;
         int other = 0;
         logic last;
         last = pin_out[4];
         for (int s = 0; s < 40; s++) begin
            cyc(1);
            if (pin_out[4] != last) toggles++;
            if (pin_out[30] != pin_out[4]) mism++;
            if (pin_out[5] != 1'b1 || pin_out[6] != 1'b0) other++;
            last = pin_out[4];
         end
         check(toggles == 40 / (TERM + 1), "R9 blink period", toggles, 40 / (TERM + 1));
         check(mism == 0, "R9 shared phase", mism, 0);
         check(other == 0, "R9 non-blink pins hold", other, 0);
      end
      check(pin_oe == 32'hFFFF_FFFF, "R3 all outputs", pin_oe, 32'hFFFF_FFFF);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule